// File: doc/BRIEF.md
# Nibble/Byte Receive Reassembler

This block sits behind a GMII-style receive interface (data lines, a data-valid line and an error line) and turns what it samples into a stream of bytes. Each byte comes with an error flag, and the final byte of a frame is marked. In byte mode, every sampled data value is one byte. In nibble (MII) mode, the block pairs successive 4-bit samples into bytes.

In nibble mode the block fixes the byte boundary on the start-frame delimiter 0xD5. The preamble nibbles cannot do this on their own, because a run of 5-nibbles looks the same at either phase. A clock-enable input qualifies every sample, so the block can run from a fast clock while the line runs at a fraction of that rate. A frame ends when data-valid is sampled low. To mark the final byte, the block holds back one byte, so each byte appears on the output after the byte that follows it has been sampled, or after the end of the frame has been sampled.

Top module: `rx_byte_reasm`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` and `out_last` are low until a frame produces a byte.
- R2: With `nibble_mode` low, each sample taken with `rx_dv` high is one byte. Its value is `rx_d[7:0]` and its error flag is that sample's `rx_er`. Bytes leave in arrival order, with one `out_valid` pulse per byte.
- R3: With `nibble_mode` high, only `rx_d[3:0]` is used. The earlier nibble of a pair becomes bits [3:0] of the byte and the later nibble becomes bits [7:4]. `rx_d[7:4]` has no effect.
- R4: With `nibble_mode` high and before synchronization, a byte is emitted on every second valid nibble, counted from the first nibble of the frame.
- R5: The first time the last two nibbles form 0xD5 (the later nibble 0xD, the earlier 0x5), that value is emitted as a byte at once, whatever the phase. Pairing then restarts from the next nibble.
- R6: After synchronization, a later 0xD5 that appears across a pair boundary does not change the pairing.
- R7: In nibble mode, a byte's error flag is the OR of `rx_er` over every nibble collected since the previous byte was emitted.
- R8: A sample with `rx_dv` low ends the frame. The final complete byte of the frame is output with `out_last` high. A frame that yields no complete byte produces no output.
- R9: In nibble mode, an unpaired nibble left at the end of a frame is dropped.
- R10: On clock edges where `clk_en` is low, `rx_d`, `rx_dv` and `rx_er` are ignored, and no frame end is seen.
- R11: The synchronization, phase and error-accumulation state clear at every frame end, so each frame aligns again on its own first 0xD5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Sample qualifier |
| nibble_mode | input | 1 | 1: 4-bit samples, 0: 8-bit samples; hold stable within a frame |
| rx_d | input | 8 | Receive data |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| out_valid | output | 1 | One-cycle strobe per output byte |
| out_data | output | 8 | Output byte |
| out_err | output | 1 | Error flag of the byte |
| out_last | output | 1 | Byte is the final one of its frame |

## Verification
The bench aims at a misaligned preamble, where 0xD5 straddles a pair boundary. A design that ignores the delimiter would emit 0x5D-style bytes and shift every later byte by a nibble. It then places a second 0xD5 across a boundary after sync. A design that realigns again would drop a nibble there and corrupt the tail. Frames with an odd nibble count, with error pulses on single nibbles, and with a lone nibble show whether the last flag, error merging and the trailing-nibble drop are right. Random enable gaps carry junk on the data, valid and error lines, so a design that samples when it should not shows up as extra bytes or early frame ends.

// File: rtl/rx_reasm_pkg.sv
package rx_reasm_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              err;
  } rx_byte_t;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rx_nib_pack.sv
module rx_nib_pack
  import rx_reasm_pkg::*;
#(
  parameter logic [7:0] SYNC_CODE = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              nibble_mode,
  input  logic [BYTE_W-1:0] rx_d,
  input  logic              rx_dv,
  input  logic              rx_er,
  output logic              byte_fire,
  output rx_byte_t          byte_val,
  output logic              frame_end
);
  logic [BYTE_W-1:0] asm_q, asm_n;
  logic              phase_q, phase_n;
  logic              sync_q, sync_n;
  logic              acc_q, acc_n;
  logic [BYTE_W-1:0] shifted;
  logic              merged, hit, emit;

  assign shifted = {rx_d[NIB_W-1:0], asm_q[BYTE_W-1:NIB_W]};
  assign merged  = acc_q | rx_er;
  assign hit     = !sync_q && (shifted == SYNC_CODE);
  assign emit    = phase_q | hit;

  always_comb begin
    asm_n         = asm_q;
    phase_n       = phase_q;
    sync_n        = sync_q;
    acc_n         = acc_q;
    byte_fire     = 1'b0;
    byte_val.data = rx_d;
    byte_val.err  = rx_er;
    frame_end     = 1'b0;
    if (clk_en) begin
      if (!rx_dv) begin
        frame_end = 1'b1;
        asm_n     = '0;
        phase_n   = 1'b0;
        sync_n    = 1'b0;
        acc_n     = 1'b0;
      end else if (nibble_mode) begin
        asm_n         = shifted;
        byte_fire     = emit;
        byte_val.data = shifted;
        byte_val.err  = merged;
        phase_n       = !emit;
        acc_n         = emit ? 1'b0 : merged;
        if (hit) sync_n = 1'b1;
      end else begin
        byte_fire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q   <= '0;
      phase_q <= 1'b0;
      sync_q  <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      asm_q   <= asm_n;
      phase_q <= phase_n;
      sync_q  <= sync_n;
      acc_q   <= acc_n;
    end
  end

  assert_state_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !rx_dv) |=> (!sync_q && !phase_q && !acc_q));

  assert_sync_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && clk_en && rx_dv) |=> sync_q);

  assert_pair_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && rx_dv && nibble_mode && phase_q) |=> !phase_q);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(sync_q) && $stable(phase_q) && $stable(acc_q)));
endmodule

// File: rtl/rx_tail_hold.sv
module rx_tail_hold
  import rx_reasm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  rx_byte_t          in_val,
  input  logic              frame_end,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_err,
  output logic              out_last
);
  rx_byte_t pend_q, pend_n;
  logic     pend_v_q, pend_v_n;
  rx_byte_t out_q, out_n;
  logic     ov_q, ov_n, ol_q, ol_n;

  always_comb begin
    pend_n   = pend_q;
    pend_v_n = pend_v_q;
    out_n    = out_q;
    ov_n     = 1'b0;
    ol_n     = 1'b0;
    if (in_fire) begin
      if (pend_v_q) begin
        ov_n  = 1'b1;
        out_n = pend_q;
      end
      pend_n   = in_val;
      pend_v_n = 1'b1;
    end else if (frame_end && pend_v_q) begin
      ov_n     = 1'b1;
      ol_n     = 1'b1;
      out_n    = pend_q;
      pend_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      out_q    <= '0;
      ov_q     <= 1'b0;
      ol_q     <= 1'b0;
    end else begin
      pend_q   <= pend_n;
      pend_v_q <= pend_v_n;
      out_q    <= out_n;
      ov_q     <= ov_n;
      ol_q     <= ol_n;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = out_q.data;
  assign out_err   = out_q.err;
  assign out_last  = ol_q;

  assert_last_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_valid_from_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pend_v_q));

  assert_empty_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !pend_v_q);
endmodule

// File: rtl/rx_byte_reasm.sv
module rx_byte_reasm
  import rx_reasm_pkg::*;
#(
  parameter logic [7:0] SYNC_CODE  = 8'hD5,
  parameter int         RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              nibble_mode,
  input  logic [BYTE_W-1:0] rx_d,
  input  logic              rx_dv,
  input  logic              rx_er,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_err,
  output logic              out_last
);
  logic     rst_s_n;
  logic     fire, fend;
  rx_byte_t bval;

  rx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  rx_nib_pack #(.SYNC_CODE(SYNC_CODE)) u_pack (
    .clk(clk), .rst_n(rst_s_n), .clk_en(clk_en), .nibble_mode(nibble_mode),
    .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er),
    .byte_fire(fire), .byte_val(bval), .frame_end(fend));

  rx_tail_hold u_hold (
    .clk(clk), .rst_n(rst_s_n), .in_fire(fire), .in_val(bval), .frame_end(fend),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err), .out_last(out_last));

  assert_mid_byte_src_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_last) |-> $past(clk_en && rx_dv));

  assert_last_on_end_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && out_last) |-> $past(clk_en && !rx_dv));

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_s_n |-> (!out_valid && !out_last));
endmodule

// File: tb/sim_rx_byte_reasm.sv
module sim_rx_byte_reasm;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_en, nibble_mode, rx_dv, rx_er;
  logic [7:0] rx_d;
  logic       out_valid, out_err, out_last;
  logic [7:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] sym_d[$];
  logic       sym_e[$];
  logic [9:0] exp_q[$];
  logic [9:0] obs_q[$];

  always #2 clk = ~clk;

  rx_byte_reasm u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .nibble_mode(nibble_mode),
    .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err), .out_last(out_last));

  always @(negedge clk)
    if (rst_n && out_valid) obs_q.push_back({out_last, out_err, out_data});

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void build_exp(bit mii);
    bit odd = 1'b1;
    bit sy = 1'b0;
    logic [7:0] b = 8'h00;
    bit be = 1'b0;
    exp_q.delete();
    for (int i = 0; i < sym_d.size(); i++) begin
      if (!mii) begin
        exp_q.push_back({1'b0, sym_e[i], sym_d[i]});
      end else begin
        odd = !odd;
        b = {sym_d[i][3:0], b[7:4]};
        be = be | sym_e[i];
        if (!sy && b == 8'hD5) begin odd = 1'b1; sy = 1'b1; end
        if (odd) begin exp_q.push_back({1'b0, be, b}); be = 1'b0; end
      end
    end
    if (exp_q.size() > 0) exp_q[exp_q.size()-1][9] = 1'b1;
  endfunction

  task automatic drive(input logic [7:0] d, input logic dv, input logic er, input logic en);
    @(negedge clk);
    rx_d = d; rx_dv = dv; rx_er = er; clk_en = en;
  endtask

  task automatic run_frame(input bit mii, input bit gaps, input string req);
    nibble_mode = mii;
    build_exp(mii);
    obs_q.delete();
    for (int i = 0; i < sym_d.size(); i++) begin
      if (gaps) begin
        int k = $urandom % 4;
        for (int g = 0; g < k; g++)
          drive($urandom, $urandom, $urandom, 1'b0);
      end
      drive(mii ? {4'($urandom), sym_d[i][3:0]} : sym_d[i], 1'b1, sym_e[i], 1'b1);
    end
    drive($urandom, 1'b0, 1'b0, 1'b1);
    for (int g = 0; g < 3; g++) drive($urandom, 1'b0, $urandom, gaps ? 1'($urandom) : 1'b1);
    drive(8'h00, 1'b0, 1'b0, 1'b0);
    check(obs_q.size() == exp_q.size(), req, 10'(obs_q.size()), 10'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      check(obs_q[i] == exp_q[i], req, obs_q[i], exp_q[i]);
  endtask

  task automatic push_nibs(input logic [3:0] n, input int cnt, input logic e);
    for (int i = 0; i < cnt; i++) begin sym_d.push_back({4'h0, n}); sym_e.push_back(e); end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; clk_en = 1'b0; nibble_mode = 1'b0; rx_d = '0; rx_dv = 1'b0; rx_er = 1'b0;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_last, "R1", {8'h0, out_valid, out_last}, 10'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_last, "R1", {8'h0, out_valid, out_last}, 10'h0);

    // R2 byte mode, with error on one byte
    sym_d.delete(); sym_e.delete();
    for (int i = 0; i < 6; i++) begin sym_d.push_back(8'hA0 + 8'(i)); sym_e.push_back(i == 2); end
    run_frame(1'b0, 1'b0, "R2");
    // R10 byte mode with enable gaps and junk lines
    run_frame(1'b0, 1'b1, "R10");

    // R5 misaligned delimiter, R6 later D5 across boundary, R7 error merge, R9 odd tail, R3
    sym_d.delete(); sym_e.delete();
    push_nibs(4'h5, 6, 1'b0);
    push_nibs(4'hD, 1, 1'b0);
    push_nibs(4'h3, 1, 1'b1);
    push_nibs(4'h5, 1, 1'b0);
    push_nibs(4'hD, 1, 1'b0);
    push_nibs(4'h7, 1, 1'b0);
    push_nibs(4'h9, 1, 1'b1);
    build_exp(1'b1);
    // spec values: 55 55 55 D5 53(err) 7D(last)
    check(exp_q.size() == 6 && exp_q[3][7:0] == 8'hD5 && exp_q[4] == {2'b01, 8'h53}
          && exp_q[5] == {2'b10, 8'h7D}, "R5", exp_q[5], {2'b10, 8'h7D});
    run_frame(1'b1, 1'b0, "R5 R6 R7 R9 R3");
    // R11 same frame again with gaps: must realign afresh
    run_frame(1'b1, 1'b1, "R11");

    // R4 aligned preamble, even count
    sym_d.delete(); sym_e.delete();
    push_nibs(4'h5, 7, 1'b0);
    push_nibs(4'hD, 1, 1'b0);
    push_nibs(4'hE, 2, 1'b0);
    run_frame(1'b1, 1'b0, "R4");

    // R8 lone nibble: no output
    sym_d.delete(); sym_e.delete();
    push_nibs(4'h6, 1, 1'b1);
    run_frame(1'b1, 1'b0, "R8");

    // random frames
    for (int f = 0; f < 40; f++) begin
      bit mii = 1'($urandom);
      int len = 1 + ($urandom % 24);
      sym_d.delete(); sym_e.delete();
      if (mii && ($urandom % 2)) begin
        push_nibs(4'h5, 1 + ($urandom % 6), 1'b0);
        push_nibs(4'hD, 1, 1'b0);
      end
      for (int i = 0; i < len; i++) begin
        sym_d.push_back(8'($urandom));
        sym_e.push_back(($urandom % 8) == 0);
      end
      run_frame(mii, 1'($urandom), mii ? "R7" : "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule